// File: doc/BRIEF.md
# AVSBus Read Bridge Master

This block is a serial master that carries out one adaptive-voltage read transaction as a fixed pair of SPI-style frames. A host writes a 32-bit command word into the data register. If the bridge is enabled and idle, that write starts the transaction. The first frame shifts the command out on MOSI, most significant bit first, and ignores MISO. After one serial-clock period with chip select high, the second frame holds MOSI low and captures 32 bits from MISO. Capture starts on the first bit, with no lead-in delay.

The serial clock idles low. The master launches data on the rising edge and samples on the falling edge (CPOL=0, CPHA=1). The divider value is computed at elaboration as reference MHz / (8 × bus MHz) − 1. One serial period is then 8 × (divider + 1) reference clocks. At the defaults (100 MHz reference, 10 MHz target) the divider is 0 and one period is 8 cycles.

The host reads a status word and the received-data register. Sticky error bits record rejected starts. A command-register write with bit 30 set clears them.

Top module: `avs_bridge_master`

## Requirements
- R1: After reset, status and rx_data are zero, csn is high, and sclk and mosi are low.
- R2: A data write (wr_en=1, wr_sel=1) while enable=1 and idle starts a transaction. Status bit 31 (ongoing) and csn low both appear in the cycle after the write. Bit 31 stays set until the second frame ends, and csn is high whenever bit 31 is clear.
- R3: Frame one gives exactly 32 rising sclk edges and shifts the written word out on mosi MSB first. Each bit is stable at the falling edge that ends its period.
- R4: Frame two gives exactly 32 rising sclk edges and keeps mosi low. It samples miso at each falling edge and stores the bits MSB first in rx_data.
- R5: sclk is low when idle. Its period inside a frame is 8 × (REF_MHZ/(8×BUS_MHZ)) reference clocks, which is 8 at the defaults.
- R6: Between the two frames, csn stays high for exactly one serial period (8 clocks at the defaults).
- R7: rx_data changes only in the cycle in which ongoing falls. It holds its value for the whole of the next transaction.
- R8: A data write while ongoing is set is ignored: the running transfer keeps its original word. The write sets sticky status bit 26.
- R9: A data write while enable=0 starts nothing and leaves csn high and rx_data unchanged. It sets sticky status bit 24.
- R10: A command write (wr_sel=0) with wr_data bit 30 set clears status bits 26 and 24. A command write without bit 30 leaves them unchanged.
- R11: sclk toggles only while csn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Bridge enable; starts are refused while low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 1 selects the data register, 0 the command register |
| wr_data | input | 32 | Host write value |
| miso | input | 1 | Serial data from the slave |
| status | output | 32 | Bit 31 ongoing, bit 26 write-while-busy, bit 24 write-while-disabled |
| rx_data | output | 32 | Word captured in frame two |
| sclk | output | 1 | Serial clock, idles low |
| csn | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |

## Verification
The bench sweeps a walking-one pattern and several dense patterns through both frames. A bit-order or off-by-one error in the shifter would show up as a rotated or truncated word, either in the captured MOSI stream or in rx_data. The bench measures the sclk period and the gap cycle by cycle. A wrong divider formula or a two-period gap would show as a wrong cycle count, and a clock that runs outside chip select would be caught. It writes while busy and while disabled. A design that restarted in either case, or failed to flag it, would corrupt the running transfer or leave the sticky bits clear. It also clears the flags with command words that have bit 30 set and with words that do not, to catch a decoder that looks at the wrong bit.

// File: rtl/avs_bridge_pkg.sv
package avs_bridge_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SEND  = 2'd1,
      SEQ_GAP   = 2'd2,
      SEQ_RECV  = 2'd3
   } seq_state_t;

   localparam int unsigned ST_ONGOING  = 31;
   localparam int unsigned ST_ERR_BUSY = 26;
   localparam int unsigned ST_ERR_DIS  = 24;
   localparam int unsigned CMD_CLEAR   = 30;
endpackage

// File: rtl/avs_tick_gen.sv
module avs_tick_gen #(
   parameter int unsigned HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (!run)                     cnt_q <= '0;
            else if (cnt_q == CW'(HALF - 1))   cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/avs_status_regs.sv
module avs_status_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic busy,
   input  logic wr_en,
   input  logic wr_sel,
   input  logic clr_bit,
   output logic start,
   output logic err_busy,
   output logic err_dis
);
   logic data_wr, cmd_clr;
   assign data_wr = wr_en && wr_sel;
   assign cmd_clr = wr_en && !wr_sel && clr_bit;
   assign start   = data_wr && enable && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_busy <= 1'b0;
         err_dis  <= 1'b0;
      end else if (cmd_clr) begin
         err_busy <= 1'b0;
         err_dis  <= 1'b0;
      end else if (data_wr) begin
         if (!enable)   err_dis  <= 1'b1;
         else if (busy) err_busy <= 1'b1;
      end
   end

   p_busy_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && enable && busy) |=> err_busy);
   p_dis_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !enable) |=> err_dis);
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && clr_bit) |=> (!err_busy && !err_dis));
endmodule

// File: rtl/avs_frame_seq.sv
module avs_frame_seq
   import avs_bridge_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              csn,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_data
);
   localparam int unsigned BW = $clog2(WORD_W);

   seq_state_t        state_q;
   logic              ph_q;
   logic [BW-1:0]     bit_q;
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-2:0] rx_q;
   logic              last_bit;

   assign busy     = (state_q != SEQ_IDLE);
   assign last_bit = (bit_q == BW'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         ph_q    <= 1'b0;
         bit_q   <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         rx_data <= '0;
         sclk    <= 1'b0;
         csn     <= 1'b1;
         mosi    <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (start) begin
               state_q <= SEQ_SEND;
               csn     <= 1'b0;
               tx_q    <= cmd_word;
               bit_q   <= '0;
               ph_q    <= 1'b0;
            end
            SEQ_SEND, SEQ_RECV: if (tick) begin
               if (!ph_q) begin
                  sclk <= 1'b1;
                  ph_q <= 1'b1;
                  if (state_q == SEQ_SEND) begin
                     mosi <= tx_q[WORD_W-1];
                     tx_q <= {tx_q[WORD_W-2:0], 1'b0};
                  end
               end else begin
                  sclk <= 1'b0;
                  ph_q <= 1'b0;
                  if (state_q == SEQ_RECV) rx_q <= {rx_q[WORD_W-3:0], miso};
                  if (last_bit) begin
                     bit_q <= '0;
                     csn   <= 1'b1;
                     if (state_q == SEQ_SEND) begin
                        state_q <= SEQ_GAP;
                     end else begin
                        state_q <= SEQ_IDLE;
                        rx_data <= {rx_q, miso};
                     end
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            SEQ_GAP: if (tick) begin
               if (!ph_q) begin
                  ph_q <= 1'b1;
               end else begin
                  ph_q    <= 1'b0;
                  state_q <= SEQ_RECV;
                  csn     <= 1'b0;
                  mosi    <= 1'b0;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   p_clk_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
      csn |-> !sclk);
   p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> csn);
   p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(rx_data));
   p_recv_mosi_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RECV) |-> !mosi);
endmodule

// File: rtl/avs_bridge_master.sv
module avs_bridge_master
   import avs_bridge_pkg::*;
#(
   parameter int unsigned REF_MHZ = 100,
   parameter int unsigned BUS_MHZ = 10,
   parameter int unsigned WORD_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              miso,
   output logic [31:0]       status,
   output logic [WORD_W-1:0] rx_data,
   output logic              sclk,
   output logic              csn,
   output logic              mosi
);
   localparam int unsigned DIV  = REF_MHZ / (8 * BUS_MHZ) - 1;
   localparam int unsigned HALF = 4 * (DIV + 1);

   generate
      if (REF_MHZ < 8 * BUS_MHZ) begin : g_bad_ratio
         $error("reference clock must be at least 8x the bus clock");
      end
      if (WORD_W != 32) begin : g_bad_width
         $error("frame width must be 32 bits");
      end
   endgenerate

   logic tick, busy, start, err_busy, err_dis;

   avs_status_regs u_status (
      .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy),
      .wr_en(wr_en), .wr_sel(wr_sel), .clr_bit(wr_data[CMD_CLEAR]),
      .start(start), .err_busy(err_busy), .err_dis(err_dis)
   );

   avs_tick_gen #(.HALF(HALF)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   avs_frame_seq #(.WORD_W(WORD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(wr_data[WORD_W-1:0]),
      .tick(tick), .miso(miso), .busy(busy), .sclk(sclk), .csn(csn),
      .mosi(mosi), .rx_data(rx_data)
   );

   always_comb begin
      status              = '0;
      status[ST_ONGOING]  = busy;
      status[ST_ERR_BUSY] = err_busy;
      status[ST_ERR_DIS]  = err_dis;
   end
endmodule

// File: tb/test_avs_bridge_master.sv
module test_avs_bridge_master;
   localparam int REF_MHZ = 100;
   localparam int BUS_MHZ = 10;
   localparam int PER     = 8 * (REF_MHZ / (8 * BUS_MHZ));

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, miso = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] status, rx_data;
   logic sclk, csn, mosi;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   avs_bridge_master #(.REF_MHZ(REF_MHZ), .BUS_MHZ(BUS_MHZ), .WORD_W(32)) i_avs_bridge_master (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .miso(miso), .status(status), .rx_data(rx_data),
      .sclk(sclk), .csn(csn), .mosi(mosi)
   );

   // serial monitor and slave model, sampled on falling clk edges
   logic [31:0] resp_word = '0, cap = '0;
   logic psclk = 1'b0, pcsn = 1'b1;
   int frame = 0, rises = 0, f1_rises = 0, last_rise = 0;
   int per_bad = 0, idle_bad = 0, mosi2_bad = 0, gap = 0;

   always @(negedge clk) begin
      if (csn && sclk) idle_bad++;
      if (!csn && pcsn) begin
         if (frame == 1) f1_rises = rises;
         frame++;
         rises = 0;
      end
      if (sclk && !psclk) begin
         if (rises > 0 && (cyc - last_rise) != PER) per_bad++;
         last_rise = cyc;
         rises++;
         if (frame == 2) begin
            if (mosi) mosi2_bad++;
            if (rises <= 32) miso = resp_word[32 - rises];
         end
      end
      if (!sclk && psclk && frame == 1) cap = {cap[30:0], mosi};
      if (csn && status[31]) gap++;
      psclk = sclk;
      pcsn  = csn;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic run_txn(input logic [31:0] cmd, input logic [31:0] resp, input logic busy_poke);
      logic [31:0] old_rx;
      int t;
      old_rx = rx_data;
      resp_word = resp;
      frame = 0; rises = 0; f1_rises = 0; cap = '0; gap = 0;
      per_bad = 0; idle_bad = 0; mosi2_bad = 0;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = cmd;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      check("R2 ongoing set", {31'd0, status[31]}, 32'd1);
      check("R2 csn low", {31'd0, csn}, 32'd0);
      if (busy_poke) begin
         repeat (20) @(negedge clk);
         wr_en = 1'b1; wr_sel = 1'b1; wr_data = ~cmd;
         @(negedge clk);
         wr_en = 1'b0; wr_data = '0;
         check("R8 busy flag", {31'd0, status[26]}, 32'd1);
      end
      t = 0;
      while (status[31] && t < 2000) begin
         check("R7 rx held", rx_data, old_rx);
         @(negedge clk);
         t++;
      end
      check("R2 completes", {31'd0, status[31]}, 32'd0);
      check("R3 mosi word", cap, cmd);
      check("R3 frame1 edges", f1_rises, 32);
      check("R4 rx word", rx_data, resp);
      check("R4 frame2 edges", rises, 32);
      check("R4 mosi low", mosi2_bad, 0);
      check("R5 sclk period", per_bad, 0);
      check("R6 gap cycles", gap, PER);
      check("R11 sclk in frame", idle_bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] keep;
      repeat (3) @(negedge clk);
      check("R1 status", status, 32'd0);
      check("R1 rx_data", rx_data, 32'd0);
      check("R1 pins", {29'd0, csn, sclk, mosi}, 32'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 sclk idle", {31'd0, sclk}, 32'd0);

      // R9: disabled write
      host_wr(1'b1, 32'hDEAD_BEEF);
      repeat (10) begin
         @(negedge clk);
         check("R9 csn high", {31'd0, csn}, 32'd1);
      end
      check("R9 dis flag", status, 32'h0100_0000);
      check("R9 rx unchanged", rx_data, 32'd0);
      host_wr(1'b0, 32'h0000_0001);
      check("R10 no clear", status, 32'h0100_0000);
      host_wr(1'b0, 32'h4000_0000);
      check("R10 clear", status, 32'd0);

      enable = 1'b1;
      for (int i = 0; i < 32; i++) begin
         run_txn(32'd1 << i, ({16'(i * 37), 16'(~i)}) ^ 32'h1234_5678, 1'b0);
      end
      run_txn(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
      run_txn(32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
      run_txn(32'h0000_0000, 32'hFFFF_FFFF, 1'b0);

      // R8: overlapping write ignored, original word kept
      run_txn(32'h8C31_7E05, 32'hC3A5_0F96, 1'b1);
      check("R8 flag kept", status, 32'h0400_0000);
      keep = rx_data;
      host_wr(1'b0, 32'hBFFF_FFFF);
      check("R10 other bits no clear", status, 32'h0400_0000);
      host_wr(1'b0, 32'h4000_0000);
      check("R10 clear busy flag", status, 32'd0);
      check("R7 rx after idle", rx_data, keep);

      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule